// File: doc/BRIEF.md
# Synchronous Serial Port, Master or Slave

This block is a full-duplex synchronous serial port with an SPI wire interface. It takes either side of the link. As bus master it produces the serial clock from the system clock through a programmable divider. It shifts one word out on MOSI and shifts one word in from MISO at the same time. As bus slave it follows an external serial clock while its active-low select input is held low. In that role it returns its loaded word on MISO and captures MOSI. Clock polarity, clock phase, word length (8 or 16 bits) and bit order are all set by software.

Software uses a small register bus with three registers: control, status and data. A data write in the idle state loads the shift register. In master mode that write also starts a transfer. When the last bit has moved, a complete flag is raised. The block also detects two faults. A write collision is a data write made during a transfer. A mode fault is the select input being pulled low while the block is master. A mode fault takes the block off the wire at once. Each pin has its own output-enable signal. In open-drain mode those enables are gated so the pad only ever pulls low.

Top module: `spi_port`

## Requirements
- R1: The bus register addresses are: control 0, status 1, data 2. After reset, the control and status registers read 0 and every output enable is low. Control bits: [0] enable, [1] master, [2] clock idle level, [3] late phase, [4] LSB first, [5] 16-bit word, [6] open drain, [15:8] divider. Status bits: [0] complete, [1] write collision, [2] mode fault.
- R2: In master mode, a data write while idle starts a transfer of 8 bits, or 16 bits if control bit 5 is set. After the last bit, status bit 0 is set and the data register holds the received word, right-aligned with its upper bits zero.
- R3: With control bit 4 clear, bit N-1 is shifted out first. With it set, bit 0 is shifted out first. The receive side assembles bits in the same order.
- R4: While no master transfer runs, SCK rests at the level of control bit 2. With control bit 3 clear, data is sampled on the first edge of each bit and changed on the second. With it set, data is changed on the first edge and sampled on the second.
- R5: Each SCK half period lasts as many system clocks as the divider field. Divider values 0 and 1 act as 2.
- R6: In slave mode, a low select input enables the transfer. The slave shifts its loaded word out on MISO, captures MOSI at the SCK edges, and sets status bit 0 after the last bit.
- R7: If the select input goes low while the block is an enabled master, status bit 2 is set. Control bits 0 and 1 are cleared and all outputs are released. Status bit 2 stays set until software writes a 1 to it.
- R8: A data write during a transfer sets status bit 1 and leaves the shift register and the transfer unchanged. Writing a 1 to status bit 1 clears it.
- R9: Status bit 0 is cleared only when a data register access follows a status read that saw it set. A data access without that prior status read leaves it set.
- R10: When control bit 6 is set, an output enable is high only while its output value is 0.
- R11: As master, the block drives SCK and MOSI and never MISO. As slave, it drives only MISO, and only while selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| sck_i | input | 1 | Serial clock from pad (slave) |
| sck_o | output | 1 | Serial clock to pad (master) |
| sck_oe | output | 1 | Serial clock pad enable |
| mosi_i | input | 1 | MOSI from pad (slave data in) |
| mosi_o | output | 1 | MOSI to pad (master data out) |
| mosi_oe | output | 1 | MOSI pad enable |
| miso_i | input | 1 | MISO from pad (master data in) |
| miso_o | output | 1 | MISO to pad (slave data out) |
| miso_oe | output | 1 | MISO pad enable |
| ss_n_i | input | 1 | Active-low slave select from pad |

## Verification
Two functions can meet in the same window: a transfer in progress and a new data write. The bench provokes this by writing a second word a few clocks after a master transfer starts, and again while a slave is still selected after its word. It then judges three things: the collision flag is raised, the word serialised on MOSI and received in master loopback is still the first word, and the slave's MISO level still reflects its received word and not the rejected one. A second overlap, a completion flag set while a data read occurs without a prior status read, is judged by the flag staying set.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
    localparam int WORD_W  = 16;
    localparam int SHORT_W = 8;
    localparam int BAUD_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int MIN_DIV = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

    typedef struct packed {
        logic [BAUD_W-1:0] div;
        logic              rsv;
        logic              od;
        logic              wide;
        logic              lsb;
        logic              cpha;
        logic              cpol;
        logic              master;
        logic              en;
    } ctrl_t;
endpackage

// File: rtl/spi_port_baud.sv
module spi_port_baud #(
    parameter int BAUD_W  = 8,
    parameter int MIN_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [BAUD_W-1:0] div_i,
    output logic              tick_o
);
    localparam logic [BAUD_W-1:0] FLOOR = BAUD_W'(MIN_DIV);

    logic [BAUD_W-1:0] cnt_d, cnt_q;
    logic [BAUD_W-1:0] limit;

    always_comb begin
        limit  = (div_i < FLOOR) ? FLOOR : div_i;
        tick_o = run_i && (cnt_q == limit - 1'b1);
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // half periods never shorter than two clocks
    p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o) else $error("divider ticked on consecutive clocks");
endmodule

// File: rtl/spi_port_engine.sv
module spi_port_engine #(
    parameter int WORD_W  = 16,
    parameter int SHORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              master_i,
    input  logic              cpol_i,
    input  logic              cpha_i,
    input  logic              lsb_i,
    input  logic              wide_i,
    input  logic              tick_i,
    input  logic              start_i,
    input  logic [WORD_W-1:0] load_i,
    input  logic              abort_i,
    input  logic              sck_i,
    input  logic              ss_n_i,
    input  logic              din_i,
    output logic              busy_o,
    output logic              run_o,
    output logic              done_o,
    output logic [WORD_W-1:0] rx_o,
    output logic              sck_o,
    output logic              dout_o,
    output logic              sel_o,
    output logic              ss_low_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic [WORD_W-1:0] rx;
        logic [CNT_W-1:0]  cnt;
        logic              samp;
        logic              half;
        logic              mbusy;
        logic              sck;
        logic              done;
        logic [2:0]        sck_s;
        logic [1:0]        ss_s;
    } eng_t;

    eng_t d, q;

    function automatic logic [WORD_W-1:0] trim(input logic [WORD_W-1:0] v, input logic wide);
        logic [WORD_W-1:0] r;
        r = v;
        if (!wide) r[WORD_W-1:SHORT_W] = '0;
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] push(input logic [WORD_W-1:0] v, input logic b,
                                               input logic lsb, input logic wide);
        logic [WORD_W-1:0] r;
        if (!lsb) r = {v[WORD_W-2:0], b};
        else begin
            r = v >> 1;
            if (wide) r[WORD_W-1]  = b;
            else      r[SHORT_W-1] = b;
        end
        return trim(r, wide);
    endfunction

    logic             slave_act, edge_seen, lead, bit_in;
    logic [CNT_W-1:0] nbits, cnt_nx;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.sck_s   = {q.sck_s[1:0], sck_i};
        d.ss_s    = {q.ss_s[0], ss_n_i};
        nbits     = wide_i ? CNT_W'(WORD_W) : CNT_W'(SHORT_W);
        cnt_nx    = q.cnt + 1'b1;
        slave_act = en_i && !master_i && !q.ss_s[1];
        edge_seen = 1'b0;
        lead      = 1'b0;
        bit_in    = 1'b0;

        if (master_i) begin
            if (q.mbusy && tick_i) begin
                edge_seen = 1'b1;
                lead      = !q.half;
                d.sck     = !q.sck;
                d.half    = !q.half;
            end else if (!q.mbusy) begin
                d.sck = cpol_i;
            end
        end else if (slave_act && (q.sck_s[2] != q.sck_s[1])) begin
            edge_seen = 1'b1;
            lead      = (q.sck_s[1] != cpol_i);
        end

        if (edge_seen) begin
            if (lead) begin
                if (!cpha_i)          d.samp = din_i;
                else if (q.cnt != '0) d.sr   = push(q.sr, q.samp, lsb_i, wide_i);
            end else begin
                bit_in = cpha_i ? din_i : q.samp;
                if (cnt_nx == nbits) begin
                    d.sr    = push(q.sr, bit_in, lsb_i, wide_i);
                    d.rx    = d.sr;
                    d.done  = 1'b1;
                    d.cnt   = '0;
                    d.mbusy = 1'b0;
                end else begin
                    d.cnt = cnt_nx;
                    if (!cpha_i) d.sr   = push(q.sr, bit_in, lsb_i, wide_i);
                    else         d.samp = bit_in;
                end
            end
        end

        if (!master_i && !slave_act) d.cnt = '0;

        if (start_i) begin
            d.sr   = trim(load_i, wide_i);
            d.cnt  = '0;
            d.half = 1'b0;
            d.sck  = cpol_i;
            if (master_i) d.mbusy = 1'b1;
        end

        if (abort_i) begin
            d.mbusy = 1'b0;
            d.cnt   = '0;
            d.half  = 1'b0;
            d.sck   = cpol_i;
            d.done  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ss_s <= 2'b11;
        end else begin
            q <= d;
        end
    end

    assign busy_o   = master_i ? q.mbusy : (en_i && !master_i && !q.ss_s[1]);
    assign run_o    = master_i && q.mbusy;
    assign done_o   = q.done;
    assign rx_o     = q.rx;
    assign sck_o    = q.sck;
    assign dout_o   = lsb_i ? q.sr[0] : (wide_i ? q.sr[WORD_W-1] : q.sr[SHORT_W-1]);
    assign sel_o    = en_i && !master_i && !q.ss_s[1];
    assign ss_low_o = !q.ss_s[1];

    // completion is a single-cycle event
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("completion held longer than one cycle");

    // the register side never reloads a running shifter
    p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o) else $error("shifter reloaded during a transfer");
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ss_n_i
);
    typedef struct packed {
        ctrl_t ctrl;
        logic  done;
        logic  wcol;
        logic  modf;
        logic  arm;
    } top_t;

    top_t d, q;

    logic              tick, run, busy, eng_done, dout, sel, ss_low;
    logic              start, abort, modf_hit;
    logic              wr_ctrl, wr_stat, wr_data, rd_stat, acc_data;
    logic [WORD_W-1:0] rx;
    logic              drv_m;

    spi_port_baud #(.BAUD_W(BAUD_W), .MIN_DIV(MIN_DIV)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .div_i  (q.ctrl.div),
        .tick_o (tick)
    );

    spi_port_engine #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (q.ctrl.en),
        .master_i (q.ctrl.master),
        .cpol_i   (q.ctrl.cpol),
        .cpha_i   (q.ctrl.cpha),
        .lsb_i    (q.ctrl.lsb),
        .wide_i   (q.ctrl.wide),
        .tick_i   (tick),
        .start_i  (start),
        .load_i   (bus_wdata),
        .abort_i  (abort),
        .sck_i    (sck_i),
        .ss_n_i   (ss_n_i),
        .din_i    (q.ctrl.master ? miso_i : mosi_i),
        .busy_o   (busy),
        .run_o    (run),
        .done_o   (eng_done),
        .rx_o     (rx),
        .sck_o    (sck_o),
        .dout_o   (dout),
        .sel_o    (sel),
        .ss_low_o (ss_low)
    );

    always_comb begin
        wr_ctrl  = bus_sel && bus_wr && (bus_addr == A_CTRL);
        wr_stat  = bus_sel && bus_wr && (bus_addr == A_STAT);
        wr_data  = bus_sel && bus_wr && (bus_addr == A_DATA);
        rd_stat  = bus_sel && bus_rd && (bus_addr == A_STAT);
        acc_data = bus_sel && (bus_wr || bus_rd) && (bus_addr == A_DATA);
        modf_hit = q.ctrl.en && q.ctrl.master && ss_low;
        start    = wr_data && !busy && q.ctrl.en && !modf_hit;
        abort    = modf_hit || !q.ctrl.en;

        d = q;
        if (wr_ctrl) begin
            d.ctrl     = ctrl_t'(bus_wdata);
            d.ctrl.rsv = 1'b0;
        end
        if (wr_stat && bus_wdata[1]) d.wcol = 1'b0;
        if (wr_stat && bus_wdata[2]) d.modf = 1'b0;
        if (wr_data && busy)         d.wcol = 1'b1;
        if (rd_stat && q.done)       d.arm  = 1'b1;
        if (acc_data && q.arm) begin
            d.done = 1'b0;
            d.arm  = 1'b0;
        end
        if (eng_done) d.done = 1'b1;
        if (modf_hit) begin
            d.modf        = 1'b1;
            d.ctrl.master = 1'b0;
            d.ctrl.en     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = q.ctrl;
            A_STAT:  bus_rdata = {{(WORD_W-3){1'b0}}, q.modf, q.wcol, q.done};
            A_DATA:  bus_rdata = rx;
            default: bus_rdata = '0;
        endcase
    end

    assign drv_m   = q.ctrl.en && q.ctrl.master;
    assign mosi_o  = dout;
    assign miso_o  = dout;
    assign sck_oe  = drv_m && (!q.ctrl.od || !sck_o);
    assign mosi_oe = drv_m && (!q.ctrl.od || !dout);
    assign miso_oe = sel   && (!q.ctrl.od || !dout);

    // a fault leaves the block neither enabled nor master
    p_modf_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.modf) |-> (!q.ctrl.master && !q.ctrl.en)) else $error("mode fault kept master role");

    // never drives both data lines at once
    p_dir_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mosi_oe && miso_oe)) else $error("both data lines driven");
endmodule

// File: tb/test_spi_port.sv
module test_spi_port;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_wr, bus_rd;
    logic [1:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        sck_i, sck_o, sck_oe;
    logic        mosi_i, mosi_o, mosi_oe;
    logic        miso_i, miso_o, miso_oe;
    logic        ss_n_i;
    logic        loop_en;
    logic        mosi_drv;

    always #5 clk = ~clk;

    assign miso_i = loop_en ? mosi_o : 1'b0;
    assign mosi_i = mosi_drv;

    spi_port i_spi_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_w(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_r(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    function automatic logic [15:0] mk(input logic [7:0] dv, input logic od, input logic wide,
                                       input logic lsb, input logic cpha, input logic cpol,
                                       input logic master, input logic en);
        return {dv, 1'b0, od, wide, lsb, cpha, cpol, master, en};
    endfunction

    function automatic logic [15:0] rev(input logic [15:0] w, input int n);
        logic [15:0] r = '0;
        for (int i = 0; i < 16; i++) if (i < n) r[n-1-i] = w[i];
        return r;
    endfunction

    // wire monitor: assembles MOSI bits in arrival order, measures half periods
    logic        mon_on = 1'b0;
    logic        cur_cpol = 1'b0, cur_cpha = 1'b0;
    logic        sck_last, mosi_last;
    logic [15:0] mon;
    int          gap, half_len;

    always @(negedge clk) begin
        if (!mon_on) begin
            mon <= '0;
            gap <= 0;
        end else if (sck_o != sck_last) begin
            half_len <= gap + 1;
            gap      <= 0;
            if ((sck_o != cur_cpol) == !cur_cpha) mon <= {mon[14:0], mosi_last};
        end else begin
            gap <= gap + 1;
        end
        sck_last  <= sck_o;
        mosi_last <= mosi_o;
    end

    // {cpol, cpha, lsb, wide, divider, word}
    localparam logic [27:0] VEC [8] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 8'd2, 16'h00A5},
        {1'b1, 1'b0, 1'b1, 1'b0, 8'd3, 16'h003C},
        {1'b0, 1'b1, 1'b0, 1'b1, 8'd4, 16'hBEEF},
        {1'b1, 1'b1, 1'b1, 1'b1, 8'd2, 16'h1234},
        {1'b0, 1'b1, 1'b1, 1'b0, 8'd0, 16'h0081},
        {1'b1, 1'b0, 1'b0, 1'b1, 8'd5, 16'h8001},
        {1'b0, 1'b0, 1'b1, 1'b1, 8'd1, 16'hF00D},
        {1'b1, 1'b1, 1'b0, 1'b0, 8'd7, 16'h0096}
    };

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] s, r, cap;
        logic        got;
        bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        sck_i = 0; mosi_drv = 0; ss_n_i = 1'b1; loop_en = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_r(2'd0, r); chk("R1 control after reset", r, 16'h0);
        bus_r(2'd1, s); chk("R1 status after reset", s, 16'h0);
        chk("R1 enables after reset", {sck_oe, mosi_oe, miso_oe}, 3'b000);

        // master loopback vectors: R2 R3 R4 R5 R9 R11
        for (int v = 0; v < 8; v++) begin
            logic        cpol, cpha, lsb, wide;
            logic [7:0]  dv;
            logic [15:0] w, mask;
            int          n, exp_half;
            {cpol, cpha, lsb, wide, dv, w} = VEC[v];
            n        = wide ? 16 : 8;
            mask     = wide ? 16'hFFFF : 16'h00FF;
            exp_half = (dv < 2) ? 2 : int'(dv);
            mon_on   = 1'b0;
            cur_cpol = cpol;
            cur_cpha = cpha;
            bus_w(2'd0, mk(dv, 1'b0, wide, lsb, cpha, cpol, 1'b1, 1'b1));
            repeat (3) @(negedge clk);
            chk("R4 idle clock level", sck_o, cpol);
            chk("R11 master drives sck and mosi only", {sck_oe, mosi_oe, miso_oe}, 3'b110);
            mon_on = 1'b1;
            bus_w(2'd2, w);
            got = 1'b0;
            for (int i = 0; i < 1000 && !got; i++) begin
                bus_r(2'd1, s);
                if (s[0]) got = 1'b1;
            end
            chk("R2 complete flag", got, 1'b1);
            bus_r(2'd2, r);
            chk("R2 received word", r, w & mask);
            chk("R3 R4 serial order on MOSI", mon & mask, lsb ? rev(w, n) : (w & mask));
            chk("R5 half period", half_len, exp_half);
            bus_r(2'd1, s);
            chk("R9 flag cleared after status then data", s[0], 1'b0);
        end

        // R8 master write collision and R9 clear sequence
        mon_on = 1'b0; cur_cpol = 1'b0; cur_cpha = 1'b0;
        bus_w(2'd0, mk(8'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
        repeat (3) @(negedge clk);
        mon_on = 1'b1;
        bus_w(2'd2, 16'h005A);
        repeat (3) @(negedge clk);
        bus_w(2'd2, 16'h00FF);
        bus_r(2'd1, s);
        chk("R8 collision flag", s[2:0], 3'b010);
        repeat (100) @(negedge clk);
        bus_r(2'd2, r);
        chk("R8 first word survives collision", r, 16'h005A);
        chk("R8 wire word unchanged", mon & 16'h00FF, 16'h005A);
        bus_r(2'd1, s);
        chk("R9 data read without status read keeps flag", s[0], 1'b1);
        bus_r(2'd2, r);
        bus_r(2'd1, s);
        chk("R9 flag cleared by data read after status", s[0], 1'b0);
        bus_w(2'd1, 16'h0002);
        bus_r(2'd1, s);
        chk("R8 collision cleared by writing one", s[1], 1'b0);
        mon_on = 1'b0;

        // R10 open drain
        bus_w(2'd0, mk(8'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1));
        repeat (3) @(negedge clk);
        chk("R10 high clock not driven", {sck_o, sck_oe}, 2'b10);
        bus_w(2'd0, mk(8'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
        repeat (3) @(negedge clk);
        chk("R10 low clock driven", {sck_o, sck_oe}, 2'b01);

        // R6 slave transfer, R11 slave pin roles
        loop_en = 1'b0;
        bus_w(2'd0, mk(8'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
        bus_w(2'd2, 16'h00C3);
        @(negedge clk);
        chk("R11 unselected slave releases miso", miso_oe, 1'b0);
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11 selected slave drives miso only", {sck_oe, mosi_oe, miso_oe}, 3'b001);
        cap = '0;
        for (int b = 7; b >= 0; b--) begin
            logic [7:0] pat = 8'h5A;
            mosi_drv = pat[b];
            repeat (6) @(negedge clk);
            cap = {cap[14:0], miso_o};
            sck_i = 1'b1;
            repeat (6) @(negedge clk);
            sck_i = 1'b0;
        end
        repeat (6) @(negedge clk);
        bus_r(2'd1, s);
        chk("R6 slave complete flag", s[0], 1'b1);
        chk("R6 slave word on miso", cap, 16'h00C3);
        bus_r(2'd2, r);
        chk("R6 slave received word", r, 16'h005A);
        bus_w(2'd2, 16'h00FF);
        bus_r(2'd1, s);
        chk("R8 slave collision flag", s[1], 1'b1);
        chk("R8 slave shifter untouched", miso_o, 1'b0);
        ss_n_i = 1'b1;
        bus_w(2'd1, 16'h0002);

        // R7 mode fault
        loop_en = 1'b1;
        bus_w(2'd0, mk(8'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
        repeat (3) @(negedge clk);
        ss_n_i = 1'b0;
        repeat (5) @(negedge clk);
        bus_r(2'd1, s);
        chk("R7 fault flag", s[2], 1'b1);
        bus_r(2'd0, r);
        chk("R7 master and enable cleared", r[1:0], 2'b00);
        chk("R7 outputs released", {sck_oe, mosi_oe, miso_oe}, 3'b000);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        bus_r(2'd1, s);
        chk("R7 fault flag sticky", s[2], 1'b1);
        bus_w(2'd1, 16'h0004);
        bus_r(2'd1, s);
        chk("R7 fault flag cleared by writing one", s[2], 1'b0);

        finish_run();
    end
endmodule